// File: doc/BRIEF.md
# Pulse-per-second input qualifier

This block watches a once-per-second timing input and decides whether it can be trusted. The asynchronous input first passes through a two-stage synchronizer. Edge detection follows it. A free-running counter then measures two things in cycles of the fast tick clock: how long the input stays high, and how many ticks lie between one rising edge and the next.

On every rising edge after the first, both measurements are published together and a one-cycle strobe marks them. The block checks the period against a programmable window and drives an invalid flag, which a channel controller uses to fall back to its own free-running timebase.

The flag is raised at once by a period outside the window. It is also raised when the input goes silent for longer than the upper limit plus a fixed margin; this does not wait for another edge. The flag drops only after two in-window periods in a row.

Top module: `pps_qualifier`

## Requirements
- R1: After reset, `hi_cnt` and `per_cnt` are 0, `meas_stb` is 0 and `invalid` is 1.
- R2: At each synchronized rising edge except the first after reset, `per_cnt` takes the number of tick cycles since the previous rising edge, and `meas_stb` is high for that one cycle.
- R3: In the same update, `hi_cnt` takes the number of tick cycles the input was high in the pulse that began at the previous rising edge.
- R4: Both counts saturate at 2^CNT_W-1 and never wrap.
- R5: A published period below `lim_lo` or above `lim_hi` sets `invalid` in the same cycle as the strobe. Both bounds are inclusive, so a period equal to a limit is in the window.
- R6: `invalid` clears only on the second of two consecutive in-window periods. One in-window period after a bad one leaves it set.
- R7: When LIM_MARGIN+`lim_hi` ticks have passed since the last rising edge with no new edge, `invalid` is set on the following cycle.
- R8: `meas_stb` never lasts more than one cycle, and the two counts change only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low reset |
| pps_in | input | 1 | Asynchronous pulse input |
| lim_lo | input | CNT_W | Lowest acceptable period, in ticks |
| lim_hi | input | CNT_W | Highest acceptable period, in ticks |
| hi_cnt | output | CNT_W | Latest high time, in ticks |
| per_cnt | output | CNT_W | Latest period, in ticks |
| invalid | output | 1 | Input fails validation |
| meas_stb | output | 1 | One-cycle strobe for a new measurement |

## Verification
The bench uses an 8-bit configuration with a 20..40 window. It sweeps pulse trains with periods from 16 to 48 and several high times, three pulses at each period. This separates the two sides of each inclusive boundary, and it shows the difference between one in-window period and two after a bad stretch.

A single pulse followed by silence pins the timeout to its exact cycle. Pulses longer than the counter range show saturation of both counts rather than wrap-around.

// File: rtl/pps_qualifier.sv
module pps_qualifier #(
  parameter int CNT_W      = 32,
  parameter int LIM_MARGIN = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_in,
  input  logic [CNT_W-1:0] lim_lo,
  input  logic [CNT_W-1:0] lim_hi,
  output logic [CNT_W-1:0] hi_cnt,
  output logic [CNT_W-1:0] per_cnt,
  output logic             invalid,
  output logic             meas_stb
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic             s1, s2, s3, armed, one_good;
  logic [CNT_W-1:0] run_per, run_hi;
  logic [CNT_W:0]   to_lim;

  wire rise = s2 & ~s3;
  wire [CNT_W-1:0] per_next = (run_per == MAXV) ? MAXV : run_per + 1'b1;
  wire [CNT_W-1:0] hi_next  = (run_hi == MAXV) ? MAXV : run_hi + 1'b1;
  wire in_win = (per_next >= lim_lo) && (per_next <= lim_hi);
  assign to_lim = {1'b0, lim_hi} + (CNT_W+1)'(LIM_MARGIN);
  wire timeout = ({1'b0, run_per} >= to_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3} <= '0;
      run_per      <= '0;
      run_hi       <= '0;
      armed        <= 1'b0;
      one_good     <= 1'b0;
      hi_cnt       <= '0;
      per_cnt      <= '0;
      invalid      <= 1'b1;
      meas_stb     <= 1'b0;
    end else begin
      s1 <= pps_in;
      s2 <= s1;
      s3 <= s2;
      meas_stb <= rise & armed;
      if (rise) begin
        armed   <= 1'b1;
        run_per <= '0;
        run_hi  <= 1;
        if (armed) begin
          per_cnt <= per_next;
          hi_cnt  <= run_hi;
          if (in_win) begin
            one_good <= 1'b1;
            if (one_good) invalid <= 1'b0;
          end else begin
            one_good <= 1'b0;
            invalid  <= 1'b1;
          end
        end
      end else begin
        run_per <= per_next;
        if (s2) run_hi <= hi_next;
        if (timeout) begin
          one_good <= 1'b0;
          invalid  <= 1'b1;
        end
      end
    end
  end
endmodule

module pps_qualifier_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] lim_lo,
  input logic [CNT_W-1:0] lim_hi,
  input logic [CNT_W-1:0] hi_cnt,
  input logic [CNT_W-1:0] per_cnt,
  input logic             invalid,
  input logic             meas_stb
);
  a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stb |=> !meas_stb);
  a_r8_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_stb |-> ($stable(per_cnt) && $stable(hi_cnt)));
  a_r3_hi_within_per: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stb |-> (hi_cnt <= per_cnt));
  a_r5_out_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb && (per_cnt < lim_lo || per_cnt > lim_hi)) |-> invalid);
  a_r6_clear_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(invalid) |-> (meas_stb && per_cnt >= lim_lo && per_cnt <= lim_hi));
endmodule

bind pps_qualifier pps_qualifier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lim_lo(lim_lo), .lim_hi(lim_hi),
  .hi_cnt(hi_cnt), .per_cnt(per_cnt), .invalid(invalid), .meas_stb(meas_stb)
);

// File: tb/pps_qualifier_tb.sv
module pps_qualifier_tb;
  localparam int W = 8;
  localparam int M = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst_n = 0, pps_in = 0;
  logic [W-1:0] lim_lo = 8'd20, lim_hi = 8'd40;
  logic [W-1:0] hi_cnt, per_cnt;
  logic invalid, meas_stb;

  int checks = 0, fails = 0;
  int exp_p[512], exp_h[512];
  int n_push = 0, n_pop = 0;
  bit m_one = 0, m_inv = 1, done = 0;

  always #2.5 clk = ~clk;

  pps_qualifier #(.CNT_W(W), .LIM_MARGIN(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .hi_cnt(hi_cnt), .per_cnt(per_cnt), .invalid(invalid), .meas_stb(meas_stb));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int p, input int h);
    exp_p[n_push] = p; exp_h[n_push] = h; n_push++;
    pps_in = 1;
    repeat (h) @(negedge clk);
    pps_in = 0;
    repeat (p - h) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && meas_stb) begin
      int pm, hm;
      pm = exp_p[n_pop] > MAXV ? MAXV : exp_p[n_pop];
      hm = exp_h[n_pop] > MAXV ? MAXV : exp_h[n_pop];
      if (pm >= lim_lo && pm <= lim_hi) begin
        if (m_one) m_inv = 0;
        m_one = 1;
      end else begin
        m_inv = 1; m_one = 0;
      end
      chk(pm == MAXV ? "R4 period" : "R2 period", per_cnt, pm);
      chk(hm == MAXV ? "R4 high" : "R3 high", hi_cnt, hm);
      chk("R5/R6 invalid", invalid, m_inv);
      n_pop++;
    end
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hi_cnt", hi_cnt, 0);
    chk("R1 per_cnt", per_cnt, 0);
    chk("R1 invalid", invalid, 1);
    chk("R1 meas_stb", meas_stb, 0);
    rst_n = 1;
    @(negedge clk);

    repeat (3) pulse(30, 5);
    // R7: single rise then silence; timeout after edge 48
    exp_p[n_push] = 100; exp_h[n_push] = 3; n_push++;
    pps_in = 1;
    repeat (3) @(negedge clk);
    pps_in = 0;
    repeat (44) @(posedge clk);
    @(negedge clk);
    chk("R7 before timeout", invalid, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 at timeout", invalid, 1);
    m_one = 0; m_inv = 1;
    repeat (52) @(negedge clk);

    for (int p = 16; p <= 48; p++)
      for (int r = 0; r < 3; r++)
        pulse(p, 1 + (p % 5) + r);

    lim_hi = 8'd250;
    pulse(300, 270);
    pulse(300, 270);
    pulse(30, 4);
    pulse(30, 4);
    pulse(30, 4);
    pps_in = 1;
    repeat (8) @(negedge clk);
    pps_in = 0;
    chk("R2 measurement count", n_pop, n_push);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule